// File: doc/BRIEF.md
# Compact Test Link Escape and Activation Tracker

This block sits on the two-wire side of a compact test link: one clock pin and one bidirectional data pin. Both pins are brought into a faster system clock through two-flop synchronizers, and the block watches them for escape sequences. An escape is a burst of data-line toggles made while the link clock is held high. The number of toggles is judged at the next link-clock rising edge and decides whether the link drops back to plain four-wire operation or begins online activation.

During activation the block counts link-clock rising edges to follow the activation packet field by field. A 12-bit packet can grow to 36 bits, depending on the data-line value at position 8. When the position passes the end of the packet, the link enters the three-phase scan format. In the same cycle the block gives a single-cycle pulse that forces the downstream test-access-port controller into its reset state. Downstream logic uses the mode and field outputs to decide how to read the data pin.

Top module: `ctrk_top`

## Requirements
- R1: A synchronous active-high reset puts the block in four-wire mode (mode_o = 0), sets field_o to 0 and holds tap_rst_o low.
- R2: Data-line transitions are counted only while the synchronized link clock is high. The count is judged and cleared at the next link-clock rising edge. Transitions made while the link clock is low are not counted.
- R3: A count of exactly 6 enters activation (mode_o = 1) with position 1 and a 12-bit packet; field_o reads 1 (activation code) for positions 1 to 4.
- R4: A count of 8 or more returns the link to four-wire mode (mode_o = 0, field_o = 0) from any mode, with no reset pulse.
- R5: Counts of 1 to 5 and of 7 leave the mode unchanged; that rising edge is handled as an ordinary edge (during activation the position still advances).
- R6: In activation, each rising edge with no escape advances the position by one. In a 12-bit packet, field_o is 2 (extension) for positions 5 to 8 and 10 (check) for positions 9 to 12.
- R7: If the data line is 0 at the rising edge that takes the position to 8, the packet becomes 36 bits. field_o then reads 3 (spare) for positions 9 to 13, 4 (delay) for 14 to 16, 5 (reverse) for 17 to 18, 6 (start) for 19 to 23, 7 (ready count) for 24 to 25, 8 (delay count) for 26 to 27, 9 (scan format) for 28 to 32 and 10 (check) for 33 to 36.
- R8: When the position exceeds the packet length, mode_o becomes 2 (three-phase scan) and tap_rst_o is high for exactly that one system-clock cycle; field_o is 0 outside activation.
- R9: A count of 6 restarts activation at position 1 with a 12-bit packet, even from three-phase scan or from the middle of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the link clock |
| rst | input | 1 | Synchronous active-high reset |
| link_clk_i | input | 1 | Asynchronous link clock pin |
| link_dat_i | input | 1 | Asynchronous link data pin |
| mode_o | output | 2 | Link mode: 0 four-wire, 1 activating, 2 three-phase scan |
| field_o | output | 4 | Current activation field index, 0 when not activating |
| tap_rst_o | output | 1 | One-cycle pulse forcing the TAP controller to reset |

## Verification
The bench looks at the count boundaries: 5 and 7 must not change the mode, while exactly 6 and any count of 8 or more must. A design using a range test in place of the equality test would start activation on 7 toggles. It toggles the data line while the clock is low; a design that counted those toggles would start activation where it must not. It drives a 0 at position 8 to select the 36-bit packet and walks every field boundary. A design that sampled the length-select bit at the wrong position, or misplaced a boundary, would show the wrong field index or enter scan format at the wrong edge. It also counts reset pulses across complete and aborted activations, so an extra or missing pulse is caught.

// File: rtl/ctrk_pkg.sv
package ctrk_pkg;

    typedef enum logic [1:0] {
        MODE_FOUR  = 2'd0,
        MODE_ACT   = 2'd1,
        MODE_SCAN3 = 2'd2
    } mode_t;

    typedef enum logic [3:0] {
        FLD_IDLE     = 4'd0,
        FLD_ACT_CODE = 4'd1,
        FLD_EXT      = 4'd2,
        FLD_SPARE    = 4'd3,
        FLD_TP_DLY   = 4'd4,
        FLD_TP_REV   = 4'd5,
        FLD_TP_START = 4'd6,
        FLD_RDY_CNT  = 4'd7,
        FLD_DLY_CNT  = 4'd8,
        FLD_SCAN_FMT = 4'd9,
        FLD_CHECK    = 4'd10
    } field_t;

    localparam int ESC_ACTIVATE = 6;
    localparam int ESC_FOUR     = 8;
    localparam int LEN_SHORT    = 12;
    localparam int LEN_LONG     = 36;
    localparam int LEN_SEL_POS  = 8;

    // Field decode from packet position and packet size.
    function automatic field_t field_of(input int pos, input logic long_pkt);
        field_t f;
        f = FLD_ACT_CODE;
        if (pos > 4) f = FLD_EXT;
        if (!long_pkt) begin
            if (pos > 8) f = FLD_CHECK;
        end else begin
            if (pos > 8)  f = FLD_SPARE;
            if (pos > 13) f = FLD_TP_DLY;
            if (pos > 16) f = FLD_TP_REV;
            if (pos > 18) f = FLD_TP_START;
            if (pos > 23) f = FLD_RDY_CNT;
            if (pos > 25) f = FLD_DLY_CNT;
            if (pos > 27) f = FLD_SCAN_FMT;
            if (pos > 32) f = FLD_CHECK;
        end
        return f;
    endfunction

endpackage

// File: rtl/ctrk_sync.sv
module ctrk_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/ctrk_escape_cnt.sv
module ctrk_escape_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lclk_s,
    input  logic             ldat_s,
    output logic             lclk_rise,
    output logic [CNT_W-1:0] esc_cnt
);
    logic lclk_d, ldat_d, toggle;

    always_ff @(posedge clk) begin
        if (rst) begin
            lclk_d <= 1'b0;
            ldat_d <= 1'b0;
        end else begin
            lclk_d <= lclk_s;
            ldat_d <= ldat_s;
        end
    end

    assign lclk_rise = lclk_s & ~lclk_d;
    assign toggle    = lclk_s & lclk_d & (ldat_s ^ ldat_d);

    always_ff @(posedge clk) begin
        if (rst)                             esc_cnt <= '0;
        else if (lclk_rise)                  esc_cnt <= '0;
        else if (toggle && esc_cnt != '1)    esc_cnt <= esc_cnt + 1'b1;
    end

    // R2: the count is cleared after each evaluation edge
    a_r2_clear_on_rise: assert property (@(posedge clk) disable iff (rst)
        lclk_rise |=> esc_cnt == '0);
    // R2: nothing is counted while the link clock is low
    a_r2_hold_when_low: assert property (@(posedge clk) disable iff (rst)
        (!lclk_s && !lclk_rise) |=> $stable(esc_cnt) || esc_cnt == '0);
endmodule

// File: rtl/ctrk_activation.sv
module ctrk_activation
    import ctrk_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lclk_rise,
    input  logic             ldat_s,
    input  logic [CNT_W-1:0] esc_cnt,
    output mode_t            mode,
    output logic [POS_W-1:0] pos,
    output logic             long_pkt,
    output logic             tap_rst
);
    localparam logic [CNT_W-1:0] C_ACT  = CNT_W'(ESC_ACTIVATE);
    localparam logic [CNT_W-1:0] C_FOUR = CNT_W'(ESC_FOUR);
    localparam logic [POS_W-1:0] P_SEL  = POS_W'(LEN_SEL_POS);
    localparam logic [POS_W-1:0] P_SHRT = POS_W'(LEN_SHORT);
    localparam logic [POS_W-1:0] P_LONG = POS_W'(LEN_LONG);

    logic [POS_W-1:0] pos_nx;
    logic             long_nx;

    assign pos_nx  = pos + 1'b1;
    assign long_nx = long_pkt | (pos_nx == P_SEL && !ldat_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_FOUR;
            pos      <= '0;
            long_pkt <= 1'b0;
            tap_rst  <= 1'b0;
        end else begin
            tap_rst <= 1'b0;
            if (lclk_rise) begin
                if (esc_cnt >= C_FOUR) begin
                    mode     <= MODE_FOUR;
                    pos      <= '0;
                    long_pkt <= 1'b0;
                end else if (esc_cnt == C_ACT) begin
                    mode     <= MODE_ACT;
                    pos      <= POS_W'(1);
                    long_pkt <= 1'b0;
                end else if (mode == MODE_ACT) begin
                    pos      <= pos_nx;
                    long_pkt <= long_nx;
                    if (pos_nx > (long_nx ? P_LONG : P_SHRT)) begin
                        mode    <= MODE_SCAN3;
                        tap_rst <= 1'b1;
                    end
                end
            end
        end
    end

    // R6: position moves only on a link-clock rising edge
    a_r6_pos_steady: assert property (@(posedge clk) disable iff (rst)
        !lclk_rise |=> $stable(pos));
    // R7: a long packet never reverts to short while activating
    a_r7_long_sticky: assert property (@(posedge clk) disable iff (rst)
        (long_pkt && mode == MODE_ACT && esc_cnt != C_ACT && esc_cnt < C_FOUR)
        |=> long_pkt);
endmodule

// File: rtl/ctrk_top.sv
module ctrk_top
    import ctrk_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int POS_W  = 6,
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       link_clk_i,
    input  logic       link_dat_i,
    output logic [1:0] mode_o,
    output logic [3:0] field_o,
    output logic       tap_rst_o
);
    logic [1:0]       pins_s;
    logic             lclk_rise;
    logic [CNT_W-1:0] esc_cnt;
    mode_t            mode;
    logic [POS_W-1:0] pos;
    logic             long_pkt;
    logic             tap_rst;
    field_t           fld;

    ctrk_sync #(.W(2), .STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({link_dat_i, link_clk_i}),
        .q_o (pins_s)
    );

    ctrk_escape_cnt #(.CNT_W(CNT_W)) u_esc (
        .clk       (clk),
        .rst       (rst),
        .lclk_s    (pins_s[0]),
        .ldat_s    (pins_s[1]),
        .lclk_rise (lclk_rise),
        .esc_cnt   (esc_cnt)
    );

    ctrk_activation #(.CNT_W(CNT_W), .POS_W(POS_W)) u_act (
        .clk       (clk),
        .rst       (rst),
        .lclk_rise (lclk_rise),
        .ldat_s    (pins_s[1]),
        .esc_cnt   (esc_cnt),
        .mode      (mode),
        .pos       (pos),
        .long_pkt  (long_pkt),
        .tap_rst   (tap_rst)
    );

    always_comb begin
        fld = FLD_IDLE;
        if (mode == MODE_ACT) fld = field_of(int'(pos), long_pkt);
    end

    assign mode_o    = mode;
    assign field_o   = fld;
    assign tap_rst_o = tap_rst;

    // R1: first cycle after reset is four-wire and quiet
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_o == 2'd0 && !tap_rst_o));
    // R8: reset pulse lasts one cycle
    a_r8_pulse_single: assert property (@(posedge clk) disable iff (rst)
        tap_rst_o |=> !tap_rst_o);
    // R8: pulse coincides with the move from activation to scan format
    a_r8_pulse_with_mode: assert property (@(posedge clk) disable iff (rst)
        tap_rst_o |-> (mode_o == 2'd2 && $past(mode_o) == 2'd1));
    // R4: a long escape always lands in four-wire mode
    a_r4_long_escape: assert property (@(posedge clk) disable iff (rst)
        (lclk_rise && esc_cnt >= CNT_W'(ESC_FOUR)) |=> (mode_o == 2'd0 && !tap_rst_o));
    // R8: field index is idle outside activation
    a_r8_field_idle: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 2'd1) |-> field_o == 4'd0);
endmodule

// File: tb/ctrk_top_tb_top.sv
module ctrk_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       link_clk = 1'b0;
    logic       link_dat = 1'b0;
    logic [1:0] mode_o;
    logic [3:0] field_o;
    logic       tap_rst_o;

    int total = 0;
    int bad   = 0;
    int pulses_seen = 0;

    typedef struct {
        int    mode;
        int    field;
        int    pulses;
        string req;
    } exp_t;
    exp_t q[$];
    event chk;

    // reference model state
    int m_mode = 0, m_pos = 0, m_long = 0, m_pulses = 0, m_pend = 0;

    always #10 clk = ~clk;

    ctrk_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .link_clk_i (link_clk),
        .link_dat_i (link_dat),
        .mode_o     (mode_o),
        .field_o    (field_o),
        .tap_rst_o  (tap_rst_o)
    );

    always @(negedge clk) if (!rst && tap_rst_o) pulses_seen++;

    function automatic int exp_field(int mode, int pos, int lng);
        if (mode != 1) return 0;
        if (pos <= 4) return 1;
        if (lng == 0) return (pos <= 8) ? 2 : 10;
        if (pos <= 8)  return 2;
        if (pos <= 13) return 3;
        if (pos <= 16) return 4;
        if (pos <= 18) return 5;
        if (pos <= 23) return 6;
        if (pos <= 25) return 7;
        if (pos <= 27) return 8;
        if (pos <= 32) return 9;
        return 10;
    endfunction

    task automatic check(string req, int act, int expv, string what);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // One link-clock period: data level t at the rising edge, hi_tog toggles
    // while high (judged at the next rise), lo_tog toggles while low.
    task automatic lcycle(bit t, int hi_tog, int lo_tog, string req);
        exp_t e;
        for (int i = 0; i < lo_tog; i++) begin
            link_dat = ~link_dat;
            repeat (3) @(negedge clk);
        end
        link_dat = t;
        repeat (8) @(negedge clk);
        link_clk = 1'b1;
        // model
        if (m_pend >= 8) begin
            m_mode = 0; m_pos = 0; m_long = 0;
        end else if (m_pend == 6) begin
            m_mode = 1; m_pos = 1; m_long = 0;
        end else if (m_mode == 1) begin
            m_pos++;
            if (m_pos == 8 && t == 1'b0) m_long = 1;
            if (m_pos > (m_long ? 36 : 12)) begin
                m_mode = 2; m_pulses++;
            end
        end
        m_pend = hi_tog;
        repeat (6) @(negedge clk);
        e.mode = m_mode; e.field = exp_field(m_mode, m_pos, m_long);
        e.pulses = m_pulses; e.req = req;
        q.push_back(e);
        -> chk;
        @(negedge clk);
        for (int i = 0; i < hi_tog; i++) begin
            link_dat = ~link_dat;
            repeat (3) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        link_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            exp_t e;
            @(chk);
            #1;
            e = q.pop_front();
            check(e.req, int'(mode_o), e.mode, "mode");
            check(e.req, int'(field_o), e.field, "field");
            check(e.req, pulses_seen, e.pulses, "pulse count");
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", int'(mode_o), 0, "mode after reset");
        check("R1", int'(field_o), 0, "field after reset");
        check("R1", int'(tap_rst_o), 0, "pulse after reset");

        lcycle(1, 0, 0, "R1");
        lcycle(1, 5, 0, "R5");
        lcycle(0, 0, 0, "R5 count five ignored");
        // R2: six toggles while low are not counted
        lcycle(1, 0, 6, "R2");
        lcycle(1, 6, 0, "R2");
        lcycle(1, 0, 0, "R3 activation start");
        // walk the 12-bit packet (data 1 at position 8)
        for (int i = 2; i <= 13; i++) lcycle(1, 0, 0, (i == 13) ? "R8" : "R6");
        lcycle(1, 7, 0, "R5");
        lcycle(1, 0, 0, "R5 count seven in scan");
        lcycle(1, 8, 0, "R4");
        lcycle(1, 0, 0, "R4 back to four-wire");
        // 36-bit packet: data 0 at position 8
        lcycle(1, 6, 0, "R3");
        lcycle(1, 0, 0, "R3");
        for (int i = 2; i <= 37; i++)
            lcycle((i == 8) ? 1'b0 : 1'b1, 0, 0, (i == 37) ? "R8" : "R7");
        // restart from scan format
        lcycle(1, 6, 0, "R9");
        lcycle(1, 0, 0, "R9 restart from scan");
        lcycle(1, 0, 0, "R6");
        lcycle(1, 5, 0, "R5");
        lcycle(1, 0, 0, "R5 position still advances");
        lcycle(1, 6, 0, "R9");
        lcycle(1, 0, 0, "R9 restart mid packet");
        lcycle(1, 9, 0, "R4");
        lcycle(1, 0, 0, "R4 abort activation");
        lcycle(1, 0, 0, "R4");
        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule